// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into a complete video raster. Two counters track the pixel position within the line and the line number within the frame. Comparators on those counters produce separate horizontal and vertical sync pulses, an active-picture flag and a composite-sync flag. The start, width and polarity of each sync pulse are set by configuration inputs.

The same timing drives a three-channel data multiplexer. On active picture lines the multiplexer forwards the incoming pixel. Everywhere else it outputs a per-channel blanking code. An optional window of blanking-interval lines can also pass input data through unchanged inside the horizontal active range, for example to carry ancillary data. The composite-sync flag is always produced for the luma channel. It is also produced for the two colour channels when the all-channels mode bit is set.

The configuration is sampled into a shadow copy once after reset and then only at the end of each frame, so a frame never mixes two settings. Every output is registered and trails the counters by exactly two clocks.

Top module: `raster_timing_gen`

## Requirements
- R1: Each line has `h_total` pixels and each frame has `v_total` lines, both counted from 0. `active` is high for pixel h of line v exactly when `h_act_start <= h < h_act_end` and `v_act_start <= v < v_act_end`.
- R2: `hsync` is asserted for pixel h exactly when `hs_start <= h < hs_start + hs_width`, on every line.
- R3: `vsync` is asserted on whole lines v with `vs_start <= v < vs_start + vs_lines`, and changes only at the first pixel of a line.
- R4: `hs_pol` and `vs_pol` separately select the asserted level (1 means the pulse is high and the idle level is low; 0 means the reverse).
- R5: When a pixel is in the active area, `pix_out` equals `pix_in` on all channels. Otherwise each channel carries its own blanking code. Channel 0 is bits [9:0] (luma), channel 1 is bits [19:10] and channel 2 is bits [29:20].
- R6: When `pass_en` is 1, lines `pass_first` to `pass_last` inclusive forward `pix_in` within the horizontal active range, while `active` stays low on those lines when they lie outside the vertical active range.
- R7: `csync_luma` is high while the horizontal or vertical sync window is open, regardless of polarity. `csync_chroma` equals `csync_luma` when `cs_all` is 1 and is 0 otherwise.
- R8: The configuration inputs are captured one clock after reset is released and then on the last pixel of each frame. Changes made inside a frame take effect only from the next frame.
- R9: All outputs are 0 during reset. Each output reflects the counter position and the `pix_in` value from two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_total | input | 12 | Pixels per line |
| h_act_start | input | 12 | First active pixel |
| h_act_end | input | 12 | First pixel after the active range |
| hs_start | input | 12 | Pixel where the horizontal sync pulse begins |
| hs_width | input | 12 | Horizontal sync width in pixels |
| hs_pol | input | 1 | Horizontal sync asserted level |
| v_total | input | 11 | Lines per frame |
| v_act_start | input | 11 | First active line |
| v_act_end | input | 11 | First line after the active range |
| vs_start | input | 11 | Line where the vertical sync pulse begins |
| vs_lines | input | 11 | Vertical sync length in lines |
| vs_pol | input | 1 | Vertical sync asserted level |
| pass_en | input | 1 | Enable the pass-through window in the blanking interval |
| pass_first | input | 11 | First pass-through line |
| pass_last | input | 11 | Last pass-through line (inclusive) |
| cs_all | input | 1 | Flag composite sync for all channels |
| blank_ch0 | input | 10 | Blanking code for channel 0 |
| blank_ch1 | input | 10 | Blanking code for channel 1 |
| blank_ch2 | input | 10 | Blanking code for channel 2 |
| pix_in | input | 30 | Input pixel, three 10-bit channels |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| active | output | 1 | Active picture flag |
| csync_luma | output | 1 | Composite sync flag for the luma channel |
| csync_chroma | output | 1 | Composite sync flag for the colour channels |
| pix_out | output | 30 | Forwarded pixel or blanking codes |

## Verification
The hardest situation to reach from the ports is a configuration change in the middle of a frame, which must leave the rest of that frame untouched. The stimulus waits for the active flag to rise in one format and then rewrites every setting at once. It measures the next horizontal sync pulse against the old width and polarity, and the per-clock reference model confirms that the switch happens exactly at the frame boundary. The pass-through window is driven to cover lines on both edges of the blanking interval. Those lines include the final line of the frame, where the line counter wraps.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    parameter int unsigned HCW = 12;  // horizontal counter width
    parameter int unsigned VCW = 11;  // vertical counter width
    parameter int unsigned CDW = 10;  // bits per channel
    parameter int unsigned NCH = 3;   // channels

    typedef logic [HCW-1:0]          hcnt_t;
    typedef logic [VCW-1:0]          vcnt_t;
    typedef logic [NCH-1:0][CDW-1:0] pix_t;

    typedef struct packed {
        hcnt_t h_total;
        hcnt_t h_act_s;
        hcnt_t h_act_e;
        hcnt_t hs_start;
        hcnt_t hs_width;
        logic  hs_pol;
        vcnt_t v_total;
        vcnt_t v_act_s;
        vcnt_t v_act_e;
        vcnt_t vs_start;
        vcnt_t vs_lines;
        logic  vs_pol;
        logic  pass_en;
        vcnt_t pass_first;
        vcnt_t pass_last;
        logic  cs_all;
        pix_t  blank;
    } cfg_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic act;
        logic cs_y;
        logic cs_c;
        pix_t data;
    } vid_t;
endpackage

// File: rtl/rtg_raster.sv
module rtg_raster
    import rtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cfg_t  cfg_in,
    output cfg_t  cfg,
    output hcnt_t h,
    output vcnt_t v,
    output logic  live
);
    typedef struct packed {
        logic  live;
        cfg_t  cfg;
        hcnt_t h;
        vcnt_t v;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.live) begin
            st_d.live = 1'b1;
            st_d.cfg  = cfg_in;
        end else if (st_q.h == st_q.cfg.h_total - hcnt_t'(1)) begin
            st_d.h = '0;
            if (st_q.v == st_q.cfg.v_total - vcnt_t'(1)) begin
                st_d.v   = '0;
                st_d.cfg = cfg_in;
            end else begin
                st_d.v = st_q.v + vcnt_t'(1);
            end
        end else begin
            st_d.h = st_q.h + hcnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign h    = st_q.h;
    assign v    = st_q.v;
    assign live = st_q.live;
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import rtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cfg_t  cfg,
    input  hcnt_t h,
    input  vcnt_t v,
    input  pix_t  pix,
    output vid_t  vid
);
    vid_t vid_d, vid_q;

    always_comb begin
        logic hs_win, vs_win, h_act, v_act, pass_ln, fwd;
        hs_win  = (h >= cfg.hs_start) && ((h - cfg.hs_start) < cfg.hs_width);
        vs_win  = (v >= cfg.vs_start) && ((v - cfg.vs_start) < cfg.vs_lines);
        h_act   = (h >= cfg.h_act_s) && (h < cfg.h_act_e);
        v_act   = (v >= cfg.v_act_s) && (v < cfg.v_act_e);
        pass_ln = cfg.pass_en && (v >= cfg.pass_first) && (v <= cfg.pass_last);
        fwd     = h_act && (v_act || pass_ln);

        vid_d.hs   = hs_win ? cfg.hs_pol : ~cfg.hs_pol;
        vid_d.vs   = vs_win ? cfg.vs_pol : ~cfg.vs_pol;
        vid_d.act  = h_act && v_act;
        vid_d.cs_y = hs_win | vs_win;
        vid_d.cs_c = (hs_win | vs_win) & cfg.cs_all;
        vid_d.data = fwd ? pix : cfg.blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vid_q <= '0;
        else        vid_q <= vid_d;
    end

    assign vid = vid_q;
endmodule

// File: rtl/rtg_outstage.sv
module rtg_outstage
    import rtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vid_t vid_in,
    output vid_t vid_out
);
    vid_t out_d, out_q;

    always_comb begin
        out_d = vid_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vid_out = out_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HCW-1:0]       h_total,
    input  logic [HCW-1:0]       h_act_start,
    input  logic [HCW-1:0]       h_act_end,
    input  logic [HCW-1:0]       hs_start,
    input  logic [HCW-1:0]       hs_width,
    input  logic                 hs_pol,
    input  logic [VCW-1:0]       v_total,
    input  logic [VCW-1:0]       v_act_start,
    input  logic [VCW-1:0]       v_act_end,
    input  logic [VCW-1:0]       vs_start,
    input  logic [VCW-1:0]       vs_lines,
    input  logic                 vs_pol,
    input  logic                 pass_en,
    input  logic [VCW-1:0]       pass_first,
    input  logic [VCW-1:0]       pass_last,
    input  logic                 cs_all,
    input  logic [CDW-1:0]       blank_ch0,
    input  logic [CDW-1:0]       blank_ch1,
    input  logic [CDW-1:0]       blank_ch2,
    input  logic [NCH*CDW-1:0]   pix_in,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 active,
    output logic                 csync_luma,
    output logic                 csync_chroma,
    output logic [NCH*CDW-1:0]   pix_out
);
    cfg_t  cfg_live, cfg_sh;
    hcnt_t h_cnt;
    vcnt_t v_cnt;
    logic  live;
    vid_t  vid_s1, vid_s2;

    always_comb begin
        cfg_live            = '0;
        cfg_live.h_total    = h_total;
        cfg_live.h_act_s    = h_act_start;
        cfg_live.h_act_e    = h_act_end;
        cfg_live.hs_start   = hs_start;
        cfg_live.hs_width   = hs_width;
        cfg_live.hs_pol     = hs_pol;
        cfg_live.v_total    = v_total;
        cfg_live.v_act_s    = v_act_start;
        cfg_live.v_act_e    = v_act_end;
        cfg_live.vs_start   = vs_start;
        cfg_live.vs_lines   = vs_lines;
        cfg_live.vs_pol     = vs_pol;
        cfg_live.pass_en    = pass_en;
        cfg_live.pass_first = pass_first;
        cfg_live.pass_last  = pass_last;
        cfg_live.cs_all     = cs_all;
        cfg_live.blank      = {blank_ch2, blank_ch1, blank_ch0};
    end

    rtg_raster u_raster (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_live),
        .cfg    (cfg_sh),
        .h      (h_cnt),
        .v      (v_cnt),
        .live   (live)
    );

    rtg_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg_sh),
        .h     (h_cnt),
        .v     (v_cnt),
        .pix   (pix_t'(pix_in)),
        .vid   (vid_s1)
    );

    rtg_outstage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .vid_in  (vid_s1),
        .vid_out (vid_s2)
    );

    assign hsync        = vid_s2.hs;
    assign vsync        = vid_s2.vs;
    assign active       = vid_s2.act;
    assign csync_luma   = vid_s2.cs_y;
    assign csync_chroma = vid_s2.cs_c;
    assign pix_out      = vid_s2.data;
endmodule

// File: rtl/rtg_check.sv
module rtg_check
    import rtg_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  live,
    input hcnt_t h,
    input vcnt_t v,
    input cfg_t  cfg,
    input logic  vsync,
    input logic  cs_y,
    input logic  cs_c
);
    logic h_last, f_last;
    assign h_last = (h == cfg.h_total - hcnt_t'(1));
    assign f_last = h_last && (v == cfg.v_total - vcnt_t'(1));

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && h_last) |=> (h == '0));                        // R1

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !h_last) |=> $stable(v));                      // R1

    AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync) |-> ($past(h, 2) == '0));               // R3

    AST_CFG_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !f_last) |=> $stable(cfg));                    // R8

    AST_CHROMA_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_c |-> cs_y);                                         // R7
endmodule

bind raster_timing_gen rtg_check u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (live),
    .h     (h_cnt),
    .v     (v_cnt),
    .cfg   (cfg_sh),
    .vsync (vsync),
    .cs_y  (csync_luma),
    .cs_c  (csync_chroma)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
    localparam int HT = 0, HAS = 1, HAE = 2, HSS = 3, HSW = 4, HPOL = 5;
    localparam int VT = 6, VAS = 7, VAE = 8, VSS = 9, VSL = 10, VPOL = 11;
    localparam int PEN = 12, PF = 13, PL = 14, CSA = 15, B0 = 16, B1 = 17, B2 = 18;
    typedef int fmt_t[19];

    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    fmt_t cur, snap;
    logic [29:0] pix_in = '0;
    logic hsync, vsync, active, csync_luma, csync_chroma;
    logic [29:0] pix_out;

    int n_chk = 0, n_bad = 0;
    bit cmp_en = 0;
    bit done = 0;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n),
        .h_total(cur[HT][11:0]), .h_act_start(cur[HAS][11:0]), .h_act_end(cur[HAE][11:0]),
        .hs_start(cur[HSS][11:0]), .hs_width(cur[HSW][11:0]), .hs_pol(cur[HPOL][0]),
        .v_total(cur[VT][10:0]), .v_act_start(cur[VAS][10:0]), .v_act_end(cur[VAE][10:0]),
        .vs_start(cur[VSS][10:0]), .vs_lines(cur[VSL][10:0]), .vs_pol(cur[VPOL][0]),
        .pass_en(cur[PEN][0]), .pass_first(cur[PF][10:0]), .pass_last(cur[PL][10:0]),
        .cs_all(cur[CSA][0]),
        .blank_ch0(cur[B0][9:0]), .blank_ch1(cur[B1][9:0]), .blank_ch2(cur[B2][9:0]),
        .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .active(active),
        .csync_luma(csync_luma), .csync_chroma(csync_chroma), .pix_out(pix_out)
    );

    // reference model: bit 35 pass-line tag, 34 hs, 33 vs, 32 act, 31 cs_y, 30 cs_c, 29:0 data
    logic [35:0] expq[$];
    int mh, mv;
    bit mlive;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expq = '{36'd0, 36'd0};
            mh = 0; mv = 0; mlive = 0;
            foreach (snap[i]) snap[i] = 0;
        end else begin
            bit hw, vw, ha, va, act, pas;
            logic [35:0] w;
            hw  = (mh >= snap[HSS]) && (mh < snap[HSS] + snap[HSW]);
            vw  = (mv >= snap[VSS]) && (mv < snap[VSS] + snap[VSL]);
            ha  = (mh >= snap[HAS]) && (mh < snap[HAE]);
            va  = (mv >= snap[VAS]) && (mv < snap[VAE]);
            act = ha && va;
            pas = (snap[PEN] != 0) && (mv >= snap[PF]) && (mv <= snap[PL]) && ha;
            w[35] = pas && !act;
            w[34] = hw ? snap[HPOL][0] : !snap[HPOL][0];
            w[33] = vw ? snap[VPOL][0] : !snap[VPOL][0];
            w[32] = act;
            w[31] = hw || vw;
            w[30] = (hw || vw) && (snap[CSA] != 0);
            w[29:0] = (act || pas) ? pix_in
                      : {snap[B2][9:0], snap[B1][9:0], snap[B0][9:0]};
            void'(expq.pop_front());
            expq.push_back(w);
            if (!mlive) begin
                mlive = 1; snap = cur;
            end else if (mh == snap[HT] - 1) begin
                mh = 0;
                if (mv == snap[VT] - 1) begin mv = 0; snap = cur; end
                else mv++;
            end else mh++;
        end
    end

    task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [35:0] w;
            w = expq[0];
            chk("R2 R4 hsync", 32'(hsync), 32'(w[34]));
            chk("R3 R4 vsync", 32'(vsync), 32'(w[33]));
            chk("R1 active", 32'(active), 32'(w[32]));
            chk("R7 csync", {30'd0, csync_luma, csync_chroma}, {30'd0, w[31], w[30]});
            if (w[35]) chk("R6 pass-through data", 32'(pix_out), 32'(w[29:0]));
            else       chk("R5 R9 data", 32'(pix_out), 32'(w[29:0]));
        end
    end

    logic [31:0] pc = 0;
    always @(negedge clk) begin
        pc <= pc + 1;
        pix_in <= {pc[9:0] ^ 10'h2a5, pc[9:0] + 10'd7, pc[9:0]};
    end

    task automatic set_fmt(fmt_t f);
        cur = f;
    endtask

    task automatic pulse_len(input logic pol, output int n);
        n = 0;
        while (hsync === pol) @(negedge clk);
        while (hsync !== pol) @(negedge clk);
        while (hsync === pol) begin n++; @(negedge clk); end
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int n;
        // format A: hsync active-low width 3, vsync active-high 2 lines
        set_fmt('{24, 6, 20, 1, 3, 0, 12, 3, 10, 0, 2, 1, 0, 0, 0, 0, 10'h040, 10'h200, 10'h200});
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {26'd0, hsync, vsync, active, csync_luma, csync_chroma}, 32'd0);
        chk("R9 reset data", 32'(pix_out), 32'd0);
        rst_n = 1;
        cmp_en = 1;
        repeat (700) @(negedge clk);
        pulse_len(1'b0, n);
        chk("R2 R4 hsync width A", 32'(n), 32'd3);

        // change mid-frame: switch to B right after active rises
        while (active !== 1'b0) @(negedge clk);
        while (active !== 1'b1) @(negedge clk);
        // format B: hsync active-high near line end, vsync low, pass lines 0..1, csync on all
        set_fmt('{16, 3, 13, 14, 2, 1, 9, 2, 8, 7, 2, 0, 1, 0, 1, 1, 10'h010, 10'h123, 10'h3ff});
        pulse_len(1'b0, n);
        chk("R8 old format kept mid-frame", 32'(n), 32'd3);
        repeat (600) @(negedge clk);
        pulse_len(1'b1, n);
        chk("R2 R4 hsync width B", 32'(n), 32'd2);

        // format C: pass window on last line of frame, luma-only csync
        set_fmt('{40, 10, 38, 0, 5, 1, 6, 1, 5, 5, 1, 1, 1, 5, 5, 0, 10'h000, 10'h155, 10'h2aa});
        repeat (1000) @(negedge clk);
        pulse_len(1'b1, n);
        chk("R2 R4 hsync width C", 32'(n), 32'd5);
        while (active !== 1'b0) @(negedge clk);
        while (active !== 1'b1) @(negedge clk);
        n = 0;
        while (active === 1'b1) begin n++; @(negedge clk); end
        chk("R1 active run length C", 32'(n), 32'd28);
        repeat (300) @(negedge clk);
        finish_up();
    end
endmodule